// File: doc/BRIEF.md
# Streaming Page Hamming ECC Generator

This block builds single-error-correcting parity over a NAND flash page while the page's bytes pass through it, one byte per cycle when `valid_i` is high. The page is split into 256-byte segments. For each segment the block keeps two parity words, each `WORD_W` bits wide (11 by default). The first word is the XOR of every data bit whose in-segment bit address has a given address bit at 1. The second word is the XOR over the complementary set, where that address bit is 0. When a stored and a recomputed word pair are XORed, the first word of the result gives the address of a flipped bit directly.

A host pulses `clear_i` before each page. It selects a 256-byte page (one segment) or a 512-byte page (two segments) with `page_512_i`, and then streams the bytes. Segment 0 accumulates into `par0_o`/`par1_o` and segment 1 into `par2_o`/`par3_o`. When a segment ends, `done_o` pulses and `code_o` presents that segment's words packed into three bytes. Correcting errors is left to the consumer.

Top module: `ecc_page_gen`

## Requirements
- R1: After reset, and in the cycle after a `clear_i` strobe, all four parity outputs are zero and `done_o` is low.
- R2: For a segment, bit k of the first word is the XOR of all data bits whose bit address has bit k set. Bit k of the second word is the XOR of all data bits whose bit address has bit k clear. An all-0xFF segment therefore gives zero in both words.
- R3: A data bit's address within its segment is {byte index (bits 10:3), bit position in the byte (bits 2:0)}. Byte index 0 is the first byte accepted after clear. A segment that is all zero except bit 5 of byte 37 gives a first word of 301 and a second word of 301 XOR 0x7FF.
- R4: In 512-byte mode, bytes 0..255 update only `par0_o` (first word) and `par1_o` (second word), and bytes 256..511 update only `par2_o` (first word) and `par3_o` (second word).
- R5: `done_o` is high for exactly one cycle: the cycle after the last byte of a segment is accepted. `done_seg_o` then gives that segment's number (0 or 1), and its words are final in that cycle.
- R6: While `done_o` is high, `code_o` equals {2'b00, second word, first word} of the segment just completed. The first word is in bits 10:0 and the second in bits 21:11, so the least significant byte holds the low bits of the first word.
- R7: In 256-byte mode only segment 0 exists. After 256 accepted bytes, further bytes are ignored until the next clear, and `par2_o`/`par3_o` stay zero.
- R8: In 512-byte mode, bytes offered after the 512th are ignored until the next clear. They raise no `done_o` and change no parity output.
- R9: A cycle with `valid_i` low changes no parity output, whatever is on `byte_i`.
- R10: `clear_i` restarts the page at byte 0 at any point in a page. A byte offered in the same cycle as `clear_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Page restart strobe |
| page_512_i | input | 1 | 1: two segments per page, 0: one segment |
| valid_i | input | 1 | `byte_i` carries a page byte this cycle |
| byte_i | input | 8 | Page data byte |
| par0_o | output | WORD_W | Segment 0 first word |
| par1_o | output | WORD_W | Segment 0 second word |
| par2_o | output | WORD_W | Segment 1 first word |
| par3_o | output | WORD_W | Segment 1 second word |
| code_o | output | CODE_W | Packed words of the last completed segment |
| done_o | output | 1 | Segment-complete pulse |
| done_seg_o | output | 1 | Number of the completed segment |

## Verification
The checker covers, on every cycle, the things that need no parity arithmetic. It checks that a clear empties all four words and that `done_o` never lasts two cycles and always follows an accepted byte. It also checks that idle cycles leave the words untouched and that segment 1 cannot move in 256-byte mode. Only the bench scenarios can show that the parity values are correct. They compare against an independent bit-address model, using a single-bit segment, an erased segment and assorted patterns with gaps. The scenarios also show that segment bytes are routed correctly across a 512-byte page, that bytes past the page end are dropped, and that a clear in mid-page restarts the page.

// File: rtl/ecc_gen_pkg.sv
`timescale 1ns/1ps
package ecc_gen_pkg;
  localparam int unsigned BIT_ADDR_W = 3;

  // parity of bits whose in-byte position has address bit j set
  function automatic logic [BIT_ADDR_W-1:0] col_set(input logic [7:0] b);
    return {^(b & 8'hF0), ^(b & 8'hCC), ^(b & 8'hAA)};
  endfunction

  function automatic logic [BIT_ADDR_W-1:0] col_clr(input logic [7:0] b);
    return {^(b & 8'h0F), ^(b & 8'h33), ^(b & 8'h55)};
  endfunction
endpackage

// File: rtl/ecc_byte_ctr.sv
`timescale 1ns/1ps
module ecc_byte_ctr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic             page_512_i,
  output logic             accept_o,
  output logic             seg_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             seg_last_o
);
  logic [IDX_W:0] cnt_q;
  logic           full_q;
  logic           page_end;

  assign accept_o   = valid_i & ~full_q & ~clear_i;
  assign seg_o      = cnt_q[IDX_W] & page_512_i;
  assign idx_o      = cnt_q[IDX_W-1:0];
  assign seg_last_o = &cnt_q[IDX_W-1:0];
  assign page_end   = accept_o & seg_last_o & (seg_o == page_512_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (page_end) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_seg_acc.sv
`timescale 1ns/1ps
module ecc_seg_acc
  import ecc_gen_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned WORD_W = IDX_W + BIT_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] set_o,
  output logic [WORD_W-1:0] clr_o
);
  logic [WORD_W-1:0] set_q, clr_q, set_d, clr_d;
  logic              row;

  assign row = ^byte_i;

  always_comb begin
    set_d = set_q;
    clr_d = clr_q;
    set_d[BIT_ADDR_W-1:0] = set_q[BIT_ADDR_W-1:0] ^ col_set(byte_i);
    clr_d[BIT_ADDR_W-1:0] = clr_q[BIT_ADDR_W-1:0] ^ col_clr(byte_i);
    for (int k = 0; k < IDX_W; k++) begin
      set_d[BIT_ADDR_W+k] = set_q[BIT_ADDR_W+k] ^ (row & idx_i[k]);
      clr_d[BIT_ADDR_W+k] = clr_q[BIT_ADDR_W+k] ^ (row & ~idx_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (clear_i) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (en_i) begin
      set_q <= set_d;
      clr_q <= clr_d;
    end
  end

  assign set_o = set_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/ecc_page_gen.sv
`timescale 1ns/1ps
module ecc_page_gen #(
  parameter int unsigned SEG_BYTES = 256,
  localparam int unsigned IDX_W    = $clog2(SEG_BYTES),
  localparam int unsigned WORD_W   = IDX_W + ecc_gen_pkg::BIT_ADDR_W,
  localparam int unsigned CODE_W   = ((2 * WORD_W + 7) / 8) * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              page_512_i,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] par0_o,
  output logic [WORD_W-1:0] par1_o,
  output logic [WORD_W-1:0] par2_o,
  output logic [WORD_W-1:0] par3_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              done_seg_o
);
  localparam int unsigned NUM_SEG = 2;

  logic             accept, seg, seg_last;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] w_set [NUM_SEG];
  logic [WORD_W-1:0] w_clr [NUM_SEG];
  logic done_q, done_seg_q;

  ecc_byte_ctr #(.IDX_W(IDX_W)) i_ctr (
    .clk_i, .rst_ni, .clear_i, .valid_i, .page_512_i,
    .accept_o(accept), .seg_o(seg), .idx_o(idx), .seg_last_o(seg_last)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    ecc_seg_acc #(.IDX_W(IDX_W)) i_acc (
      .clk_i, .rst_ni, .clear_i,
      .en_i  (accept & (seg == 1'(s))),
      .idx_i (idx),
      .byte_i,
      .set_o (w_set[s]),
      .clr_o (w_clr[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      done_seg_q <= 1'b0;
    end else begin
      done_q <= accept & seg_last;
      if (clear_i) done_seg_q <= 1'b0;
      else if (accept & seg_last) done_seg_q <= seg;
    end
  end

  assign par0_o     = w_set[0];
  assign par1_o     = w_clr[0];
  assign par2_o     = w_set[1];
  assign par3_o     = w_clr[1];
  assign done_o     = done_q;
  assign done_seg_o = done_seg_q;
  assign code_o     = CODE_W'({w_clr[done_seg_q], w_set[done_seg_q]});
endmodule

// File: rtl/ecc_page_gen_chk.sv
`timescale 1ns/1ps
module ecc_page_gen_chk #(
  parameter int unsigned WORD_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              page_512_i,
  input logic              valid_i,
  input logic [WORD_W-1:0] par0_o,
  input logic [WORD_W-1:0] par1_o,
  input logic [WORD_W-1:0] par2_o,
  input logic [WORD_W-1:0] par3_o,
  input logic              done_o
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (par0_o == '0 && par1_o == '0 && par2_o == '0 && par3_o == '0 && !done_o)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_i) && !$past(clear_i))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> ($stable(par0_o) && $stable(par1_o) && $stable(par2_o) && $stable(par3_o))); // R9

  AST_SEG1_FROZEN_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_512_i && !clear_i) |=> ($stable(par2_o) && $stable(par3_o))); // R7
endmodule

bind ecc_page_gen ecc_page_gen_chk #(.WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_ecc_page_gen.sv
`timescale 1ns/1ps
module test_ecc_page_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, clear, page_512, valid, done, done_seg;
  logic [7:0]  byte_d;
  logic [10:0] par0, par1, par2, par3;
  logic [23:0] code;

  ecc_page_gen i_ecc_page_gen (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .page_512_i(page_512),
    .valid_i(valid), .byte_i(byte_d), .par0_o(par0), .par1_o(par1),
    .par2_o(par2), .par3_o(par3), .code_o(code), .done_o(done), .done_seg_o(done_seg)
  );

  typedef struct { int seg; logic [10:0] w1; logic [10:0] w2; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0, n_done = 0;
  logic [7:0] mem [256];
  logic prev_done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [7:0] gen(input int pat, input int i);
    if (pat == 0) return 8'hFF;
    if (pat == 1) return (i == 37) ? 8'h20 : 8'h00;
    return 8'((i * pat) ^ ((i >> 3) * 7) ^ (pat << 4) ^ (i >> 5));
  endfunction

  // bit address model: {byte index, bit position}
  task automatic model(output logic [10:0] w1, output logic [10:0] w2);
    w1 = '0; w2 = '0;
    for (int a = 0; a < 2048; a++) begin
      logic [10:0] ad;
      logic bv;
      ad = 11'(a);
      bv = mem[a >> 3][a & 7];
      for (int k = 0; k < 11; k++) begin
        if (ad[k]) w1[k] = w1[k] ^ bv;
        else       w2[k] = w2[k] ^ bv;
      end
    end
  endtask

  task automatic feed_seg(input int seg, input int pat, input int gap);
    exp_t e;
    for (int i = 0; i < 256; i++) mem[i] = gen(pat, i);
    model(e.w1, e.w2);
    e.seg = seg;
    q.push_back(e);
    for (int i = 0; i < 256; i++) begin
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(negedge clk); valid = 1'b0; byte_d = 8'hA5;
      end
      @(negedge clk); valid = 1'b1; byte_d = mem[i];
    end
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic extra_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); valid = 1'b1; byte_d = 8'(i * 29 + 3);
    end
    @(negedge clk); valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  // monitor: pops expected segment results when done pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk("R5 done width", 32'(done), 32'd0);
      if (done) begin
        exp_t e;
        n_done++;
        if (q.size() == 0) chk("R5 unexpected done", 32'(done), 32'd0);
        else begin
          e = q.pop_front();
          chk("R5 done_seg", 32'(done_seg), 32'(e.seg));
          chk("R2 R4 first word", 32'(e.seg ? par2 : par0), 32'(e.w1));
          chk("R2 R4 second word", 32'(e.seg ? par3 : par1), 32'(e.w2));
          chk("R6 code", 32'(code), {8'h00, 2'b00, e.w2, e.w1});
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [10:0] s0, s1, s2, s3;
    rst_n = 1'b0; clear = 1'b0; page_512 = 1'b0; valid = 1'b0; byte_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset par", 32'({par0, par1} | {par2, par3}), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);

    // 256-byte page
    feed_seg(0, 3, 0);
    @(negedge clk);
    chk("R5 done count", 32'(n_done), 32'd1);
    s0 = par0; s1 = par1;
    extra_bytes(10);
    chk("R7 seg0 hold first", 32'(par0), 32'(s0));
    chk("R7 seg0 hold second", 32'(par1), 32'(s1));
    chk("R7 seg1 zero", 32'({par2, par3}), 32'd0);
    chk("R7 no done", 32'(n_done), 32'd1);

    do_clear();
    chk("R1 R10 clear par", 32'({par0, par1}), 32'd0);
    chk("R1 clear done", 32'(done), 32'd0);

    // 512-byte page with idle gaps
    page_512 = 1'b1;
    feed_seg(0, 5, 7);
    feed_seg(1, 9, 0);
    @(negedge clk);
    chk("R4 done count", 32'(n_done), 32'd3);
    s0 = par0; s1 = par1; s2 = par2; s3 = par3;
    extra_bytes(5);
    chk("R8 hold", 32'({par0, par1, par2, par3} == {s0, s1, s2, s3}), 32'd1);
    chk("R8 no done", 32'(n_done), 32'd3);

    // single flipped bit
    do_clear();
    page_512 = 1'b0;
    feed_seg(0, 1, 0);
    @(negedge clk);
    chk("R3 first word", 32'(par0), 32'd301);
    chk("R3 second word", 32'(par1), 32'(11'd301 ^ 11'h7FF));

    // erased segment
    do_clear();
    feed_seg(0, 0, 3);
    @(negedge clk);
    chk("R2 erased words", 32'({par0, par1}), 32'd0);

    // clear mid-page, with a byte in the clear cycle
    do_clear();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); valid = 1'b1; byte_d = gen(11, i);
    end
    @(negedge clk); valid = 1'b1; byte_d = 8'h5A; clear = 1'b1;
    @(negedge clk); valid = 1'b0; clear = 1'b0;
    chk("R10 cleared mid-page", 32'({par0, par1}), 32'd0);
    chk("R10 no done", 32'(n_done), 32'd5);
    feed_seg(0, 13, 0);
    @(negedge clk);
    chk("R10 done count", 32'(n_done), 32'd6);
    chk("R5 queue drained", 32'(q.size()), 32'd0);

    summary();
    $finish;
  end
endmodule